// File: doc/BRIEF.md
# I2C EEPROM Image Preloader

This block starts a processor that has no boot ROM. From reset it keeps the processor's reset line asserted. It then reads a program image from one of two serial EEPROMs over a two-wire I2C bus, acting as the bus master, and writes each byte into working RAM. When the last byte is stored and the bus has been given back with a STOP, it lets the processor run. A single input picks which EEPROM supplies the image. The two devices are told apart only by their 7-bit bus address.

The bus pins use open-drain encoding. Each output is a "pull low" request, and the board's pull-ups provide the high level. The SDA level is read back on a separate input. SCL runs from the system clock through a quarter-period divider set by an input. With a 50 MHz clock, a setting of 124 gives a 100 kHz bus. RAM is reached through a write strobe that is held until the memory reports ready. This stands in for any DRAM timing. If the chosen EEPROM does not acknowledge, the block retries after a fixed pause. After a bounded number of failures it gives up, flags an error and keeps the processor in reset.

Top module: `pre_loader`

## Requirements
- R1: While reset is asserted, cpuReset is 1, sclLow and sdaLow are 0 (bus released), memWe is 0 and errFlag is 0.
- R2: cpuReset stays 1 during every RAM write and through the whole transfer. It goes to 0 only after the final byte has been accepted by RAM and a STOP has been placed on the bus. After that, cpuReset stays 0 and both bus pins stay released.
- R3: The 7-bit device address is 0x50 when imgSel is 0 and 0x51 when imgSel is 1. An address byte on the wire is {address, R/W}, with R/W = 0 for write and 1 for read, sent MSB first.
- R4: Each attempt sends the following, in order: START, the write address byte, word address byte 0x00 (high half), word address byte 0x00 (low half), a repeated START and the read address byte. SDA only changes while SCL is low, except for START and STOP.
- R5: Exactly IMG_BYTES bytes are read in one sequential burst. The master ACKs (drives SDA low on the ninth clock) after every byte except the last, which gets a NACK (SDA released) followed by STOP.
- R6: Byte n of the burst (counting from 0) is written to RAM address n, with memData equal to that byte.
- R7: memWe, memAddr and memData hold steady until a clock edge with memReady = 1. There is one accepted write per byte, and no further bus clocking happens until then.
- R8: When the device NACKs any header byte, the master issues STOP, waits RETRY_GAP clocks and restarts the header from START.
- R9: After MAX_TRIES consecutive failed attempts (8 by default), errFlag goes to 1 and stays there, the bus goes quiet and cpuReset stays 1.
- R10: Bus edges are spaced on a grid of quarterDiv+1 clocks. Every SCL high pulse lasts exactly 2*(quarterDiv+1) clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset; loading starts when it is released |
| quarterDiv | input | DIV_W | SCL quarter period minus one, in clocks |
| imgSel | input | 1 | EEPROM select: 0 selects address 0x50, 1 selects 0x51 |
| sclLow | output | 1 | 1 pulls SCL low; 0 releases it |
| sdaLow | output | 1 | 1 pulls SDA low; 0 releases it |
| sdaIn | input | 1 | Level seen on the SDA wire |
| memWe | output | 1 | RAM write request, held until memReady |
| memAddr | output | ADDR_W | RAM byte address, ADDR_W = clog2(IMG_BYTES) |
| memData | output | 8 | RAM write data |
| memReady | input | 1 | RAM accepts the write at this clock edge |
| cpuReset | output | 1 | Processor reset, 1 while the image is not yet in RAM |
| errFlag | output | 1 | Selected EEPROM never acknowledged; loading abandoned |

## Verification
The bench targets the following corner cases. The last byte must be NACKed: a design that ACKs it leaves the EEPROM driving SDA and fails the check on where the NACK falls. The divider setting of zero is run, where every quarter lasts one clock. RAM is made to stall for long stretches, so a design that advances without waiting for ready loses or repeats bytes at the wrong addresses. Both devices are present while imgSel is 1, so mixing up 0x50 and 0x51 shows up as wrong data. One run has a device that NACKs twice before answering, which catches a design that gives up early, skips the pause, or keeps a stale address counter. Another run has a device that never answers, which catches a design that loops forever or releases the processor after failure.

// File: rtl/pre_pkg.sv
package pre_pkg;

  // bus operations the serial engine can execute
  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_STOP  = 3'd1,
    OP_WRITE = 3'd2,   // 8 bits out + ack in
    OP_READ  = 3'd3,   // 8 bits in
    OP_ACK   = 3'd4    // one acknowledge bit out
  } phyOp_t;

  typedef enum logic [3:0] {
    S_START, S_DEVW, S_WHI, S_WLO, S_RSTART, S_DEVR,
    S_READ, S_MEM, S_ACK, S_STOP, S_FSTOP, S_WAIT, S_ERR, S_DONE
  } ldState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic addrClr;
    logic addrInc;
    logic dataLoad;
    logic tryInc;
    logic waitLoad;
  } dpStrobe_t;

  localparam logic [6:0] DEV_BASE = 7'h50;

endpackage

// File: rtl/pre_i2c_phy.sv
module pre_i2c_phy
  import pre_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] quarterDiv,
  input  logic             opGo,
  input  phyOp_t           opKind,
  input  logic [7:0]       txByte,
  input  logic             ackOut,
  input  logic             sdaIn,
  output logic             opDone,
  output logic             ackRx,
  output logic [7:0]       rxByte,
  output logic             busy,
  output logic             sclLow,
  output logic             sdaLow
);

  logic [DIV_W-1:0] divCnt;
  phyOp_t           kind;
  logic [1:0]       qIdx;
  logic [3:0]       bitIdx;
  logic [3:0]       lastBit;
  logic [7:0]       shiftR;
  logic             ackOutR, busyR, doneR, sclLowR, sdaLowR, ackRxR;
  logic             bitOp;

  always_comb begin
    case (kind)
      OP_WRITE: lastBit = 4'd8;
      OP_READ:  lastBit = 4'd7;
      default:  lastBit = 4'd0;
    endcase
    bitOp = (kind == OP_WRITE) || (kind == OP_READ) || (kind == OP_ACK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      kind    <= OP_STOP;
      qIdx    <= '0;
      bitIdx  <= '0;
      shiftR  <= '0;
      ackOutR <= 1'b0;
      busyR   <= 1'b0;
      doneR   <= 1'b0;
      sclLowR <= 1'b0;
      sdaLowR <= 1'b0;
      ackRxR  <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (!busyR) begin
        if (opGo) begin
          busyR   <= 1'b1;
          kind    <= opKind;
          qIdx    <= '0;
          bitIdx  <= '0;
          shiftR  <= txByte;
          ackOutR <= ackOut;
          divCnt  <= quarterDiv;
        end
      end else if (divCnt != '0) begin
        divCnt <= divCnt - 1'b1;
      end else begin
        divCnt <= quarterDiv;
        case (kind)
          OP_START: begin
            case (qIdx)
              2'd0: begin sclLowR <= 1'b1; sdaLowR <= 1'b0; end
              2'd1: sclLowR <= 1'b0;
              2'd2: sdaLowR <= 1'b1;
              default: sclLowR <= 1'b1;
            endcase
          end
          OP_STOP: begin
            case (qIdx)
              2'd0: begin sclLowR <= 1'b1; sdaLowR <= 1'b1; end
              2'd1: sclLowR <= 1'b0;
              2'd2: sdaLowR <= 1'b0;
              default: ;
            endcase
          end
          default: begin
            case (qIdx)
              2'd0: begin
                sclLowR <= 1'b1;
                if (kind == OP_WRITE)      sdaLowR <= (bitIdx < 4'd8) ? ~shiftR[7] : 1'b0;
                else if (kind == OP_ACK)   sdaLowR <= ackOutR;
                else                       sdaLowR <= 1'b0;
              end
              2'd1: sclLowR <= 1'b0;
              2'd2: begin
                if (kind == OP_WRITE) begin
                  if (bitIdx == 4'd8) ackRxR <= ~sdaIn;
                  else                shiftR <= {shiftR[6:0], 1'b0};
                end else if (kind == OP_READ) begin
                  shiftR <= {shiftR[6:0], sdaIn};
                end
              end
              default: sclLowR <= 1'b1;
            endcase
          end
        endcase
        qIdx <= qIdx + 1'b1;
        if (qIdx == 2'd3) begin
          if (bitIdx == lastBit) begin
            busyR <= 1'b0;
            doneR <= 1'b1;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
      end
    end
  end

  assign opDone = doneR;
  assign ackRx  = ackRxR;
  assign rxByte = shiftR;
  assign busy   = busyR;
  assign sclLow = sclLowR;
  assign sdaLow = sdaLowR;

  // R4
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyR && bitOp && !sclLowR && !$past(sclLowR)) |-> $stable(sdaLowR));

  // R7
  go_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    opGo |-> !busyR);

endmodule

// File: rtl/pre_datapath.sv
module pre_datapath
  import pre_pkg::*;
#(
  parameter int IMG_BYTES = 32768,
  parameter int RETRY_GAP = 100000,
  parameter int MAX_TRIES = 8,
  localparam int ADDR_W = $clog2(IMG_BYTES),
  localparam int WAIT_W = $clog2(RETRY_GAP + 1),
  localparam int TRY_W  = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [7:0]        rxByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              lastByte,
  output logic              finalTry,
  output logic              waitDone
);

  logic [ADDR_W-1:0] addrR;
  logic [7:0]        dataR;
  logic [TRY_W-1:0]  tryCnt;
  logic [WAIT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR   <= '0;
      dataR   <= '0;
      tryCnt  <= '0;
      waitCnt <= '0;
    end else begin
      if (strobe.addrClr)      addrR <= '0;
      else if (strobe.addrInc) addrR <= addrR + 1'b1;
      if (strobe.dataLoad) dataR <= rxByte;
      if (strobe.tryInc)   tryCnt <= tryCnt + 1'b1;
      if (strobe.waitLoad)     waitCnt <= WAIT_W'(RETRY_GAP);
      else if (waitCnt != '0)  waitCnt <= waitCnt - 1'b1;
    end
  end

  assign memAddr  = addrR;
  assign memData  = dataR;
  assign lastByte = (addrR == ADDR_W'(IMG_BYTES - 1));
  assign finalTry = (tryCnt == TRY_W'(MAX_TRIES - 1));
  assign waitDone = (waitCnt == '0);

  // R9
  try_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tryInc |-> !finalTry);

  // R6
  inc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.addrInc |-> !lastByte);

endmodule

// File: rtl/pre_ctrl.sv
module pre_ctrl
  import pre_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       imgSel,
  input  logic       opDone,
  input  logic       ackRx,
  input  logic       memReady,
  input  logic       lastByte,
  input  logic       finalTry,
  input  logic       waitDone,
  output logic       opGo,
  output phyOp_t     opKind,
  output logic [7:0] txByte,
  output logic       ackOut,
  output dpStrobe_t  strobe,
  output logic       memWe,
  output logic       cpuReset,
  output logic       errFlag
);

  ldState_t   state, nextState;
  logic       launched;
  logic       isOpState;
  logic [6:0] devAddr;

  assign devAddr = DEV_BASE | {6'd0, imgSel};

  always_comb begin
    opKind = OP_WRITE;
    txByte = 8'h00;
    case (state)
      S_START, S_RSTART: opKind = OP_START;
      S_DEVW:            txByte = {devAddr, 1'b0};
      S_DEVR:            txByte = {devAddr, 1'b1};
      S_READ:            opKind = OP_READ;
      S_ACK:             opKind = OP_ACK;
      S_STOP, S_FSTOP:   opKind = OP_STOP;
      default: ;
    endcase
    isOpState = !(state inside {S_MEM, S_WAIT, S_ERR, S_DONE});
    opGo      = isOpState && !launched;
    ackOut    = !lastByte;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      S_START:  if (opDone) nextState = S_DEVW;
      S_DEVW:   if (opDone) nextState = ackRx ? S_WHI : S_FSTOP;
      S_WHI:    if (opDone) nextState = ackRx ? S_WLO : S_FSTOP;
      S_WLO:    if (opDone) nextState = ackRx ? S_RSTART : S_FSTOP;
      S_RSTART: if (opDone) nextState = S_DEVR;
      S_DEVR: if (opDone) begin
        nextState      = ackRx ? S_READ : S_FSTOP;
        strobe.addrClr = ackRx;
      end
      S_READ: if (opDone) begin
        nextState       = S_MEM;
        strobe.dataLoad = 1'b1;
      end
      S_MEM:  if (memReady) nextState = S_ACK;
      S_ACK: if (opDone) begin
        nextState      = lastByte ? S_STOP : S_READ;
        strobe.addrInc = !lastByte;
      end
      S_STOP: if (opDone) nextState = S_DONE;
      S_FSTOP: if (opDone) begin
        if (finalTry) nextState = S_ERR;
        else begin
          nextState       = S_WAIT;
          strobe.tryInc   = 1'b1;
          strobe.waitLoad = 1'b1;
        end
      end
      S_WAIT: if (waitDone) nextState = S_START;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_START;
      launched <= 1'b0;
    end else begin
      state <= nextState;
      if (opDone)    launched <= 1'b0;
      else if (opGo) launched <= 1'b1;
    end
  end

  assign memWe    = (state == S_MEM);
  assign cpuReset = (state != S_DONE);
  assign errFlag  = (state == S_ERR);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> (errFlag && !opGo && cpuReset));

  // R8
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT) |-> !opGo);

endmodule

// File: rtl/pre_loader.sv
module pre_loader
  import pre_pkg::*;
#(
  parameter int IMG_BYTES = 32768,
  parameter int DIV_W     = 12,
  parameter int RETRY_GAP = 100000,
  parameter int MAX_TRIES = 8,
  localparam int ADDR_W = $clog2(IMG_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  quarterDiv,
  input  logic              imgSel,
  output logic              sclLow,
  output logic              sdaLow,
  input  logic              sdaIn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  input  logic              memReady,
  output logic              cpuReset,
  output logic              errFlag
);

  dpStrobe_t  strobe;
  phyOp_t     opKind;
  logic       opGo, opDone, ackRx, ackOut, phyBusy;
  logic [7:0] txByte, rxByte;
  logic       lastByte, finalTry, waitDone;

  pre_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .imgSel(imgSel), .opDone(opDone), .ackRx(ackRx),
    .memReady(memReady), .lastByte(lastByte), .finalTry(finalTry),
    .waitDone(waitDone), .opGo(opGo), .opKind(opKind), .txByte(txByte),
    .ackOut(ackOut), .strobe(strobe), .memWe(memWe), .cpuReset(cpuReset),
    .errFlag(errFlag)
  );

  pre_datapath #(
    .IMG_BYTES(IMG_BYTES), .RETRY_GAP(RETRY_GAP), .MAX_TRIES(MAX_TRIES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .memAddr(memAddr), .memData(memData), .lastByte(lastByte),
    .finalTry(finalTry), .waitDone(waitDone)
  );

  pre_i2c_phy #(.DIV_W(DIV_W)) phy_i (
    .clk(clk), .rstN(rstN), .quarterDiv(quarterDiv), .opGo(opGo),
    .opKind(opKind), .txByte(txByte), .ackOut(ackOut), .sdaIn(sdaIn),
    .opDone(opDone), .ackRx(ackRx), .rxByte(rxByte), .busy(phyBusy),
    .sclLow(sclLow), .sdaLow(sdaLow)
  );

  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !memReady) |=> (memWe && $stable(memAddr) && $stable(memData)));

  // R2
  released_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReset |=> (!cpuReset && !sclLow && !sdaLow && !memWe && !phyBusy));

endmodule

// File: tb/pre_loader_tb_top.sv
module pre_loader_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int IMG       = 40;
  localparam int GAP       = 300;
  localparam int MAXT      = 8;
  localparam int AW        = $clog2(IMG);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [11:0]   quarterDiv = 12'd1;
  logic          imgSel = 1'b0;
  logic          sclLow, sdaLow, memWe, cpuReset, errFlag;
  logic [AW-1:0] memAddr;
  logic [7:0]    memData;
  logic          memReady = 1'b0;
  logic          slvLow = 1'b0;
  wire           sclBus = !sclLow;
  wire           sdaBus = !(sdaLow || slvLow);

  int total = 0, bad = 0, cyc = 0;

  pre_loader #(.IMG_BYTES(IMG), .DIV_W(12), .RETRY_GAP(GAP), .MAX_TRIES(MAXT)) dut_i (
    .clk(clk), .rstN(rstN), .quarterDiv(quarterDiv), .imgSel(imgSel),
    .sclLow(sclLow), .sdaLow(sdaLow), .sdaIn(sdaBus), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .memReady(memReady),
    .cpuReset(cpuReset), .errFlag(errFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] romByte(input int dev, input int a);
    return 8'((a * 37) ^ (a >> 3) ^ (dev != 0 ? 8'hA5 : 8'h3C));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- EEPROM pair model ----------------
  bit         present[2];
  int         failFirst = 0;
  bit         slvActive = 0, slvTx = 0, txPending = 0, lastAck = 0, nackFail = 0;
  int         slvBit = 0, slvState = 0, slvDev = 0, slvPtr = 0;
  logic [7:0] slvShift = 0, txByte = 0;
  int         startCnt = 0, stopCnt = 0, attempts = 0, txCount = 0, masterAcks = 0;
  int         nackIdx = -1, logW = -1, logHi = -1, logLo = -1, logR = -1;
  bit         rsSeen = 0, stopAfterNack = 0;
  int         stopCyc = 0, gapBad = 0, gapSeen = 0;

  always @(negedge sdaBus) if (sclBus) begin
    startCnt++;
    if (nackFail) begin
      gapSeen++;
      if ((cyc - stopCyc) < GAP || (cyc - stopCyc) > GAP + 8 * (quarterDiv + 1) + 8) gapBad++;
      nackFail = 0;
    end
    if (slvActive && slvState == 3) rsSeen = 1;
    slvActive = 1; slvTx = 0; slvBit = 0; slvState = 0; slvLow = 0; txPending = 0;
  end

  always @(posedge sdaBus) if (sclBus) begin
    stopCnt++;
    stopCyc = cyc;
    if (nackIdx >= 0) stopAfterNack = 1;
    slvActive = 0; slvTx = 0;
  end

  always @(posedge sclBus) if (slvActive) begin
    if (!slvTx && slvBit < 8) slvShift = {slvShift[6:0], sdaBus};
    if (slvTx && slvBit == 8) begin
      lastAck = !sdaBus;
      if (lastAck) masterAcks++;
      else nackIdx = txCount - 1;
    end
    slvBit++;
  end

  always @(negedge sclBus) if (slvActive) begin
    if (!slvTx && slvBit == 8) begin
      bit ack, match;
      int d;
      d = slvShift[1];
      match = (slvShift[7:2] == 6'b101000) && present[d];
      ack = 0;
      case (slvState)
        0: if (!slvShift[0]) begin
             attempts++; logW = slvShift;
             ack = match && (attempts > failFirst);
             slvDev = d; slvState = 1;
           end else begin
             logR = slvShift; ack = match && (d == slvDev); txPending = ack;
           end
        1: begin logHi = slvShift; slvPtr = {slvShift, slvPtr[7:0]}; ack = 1; slvState = 2; end
        default: begin logLo = slvShift; slvPtr = {slvPtr[15:8], slvShift}; ack = 1; slvState = 3; end
      endcase
      slvLow = ack;
      if (!ack) begin slvActive = 0; nackFail = 1; end
    end else if (slvBit == 9) begin
      slvBit = 0; slvLow = 0;
      if (txPending || (slvTx && lastAck)) begin
        txPending = 0; slvTx = 1;
        txByte = romByte(slvDev, slvPtr);
        slvPtr++; txCount++;
        slvLow = !txByte[7];
      end else if (slvTx) begin
        slvTx = 0; slvActive = 0;
      end
    end else if (slvTx && slvBit >= 1 && slvBit <= 7) begin
      slvLow = !txByte[7 - slvBit];
    end else if (slvTx && slvBit == 8) begin
      slvLow = 0;
    end
  end

  // ---------------- RAM model and timing monitors ----------------
  int  readyPct = 100, wrCount = 0, wrBad = 0, holdBad = 0, rstBad = 0;
  int  firstBadAddr = -1, firstBadData = -1;
  int  sclBad = 0, sclSeen = 0, hiCnt = 0;
  bit  meas = 0, prevScl = 1, prevPend = 0;
  logic [AW-1:0] prevAddr = '0;
  logic [7:0]    prevData = '0;
  int  expSel = 0;

  always @(negedge clk) begin
    memReady <= (($urandom % 100) < readyPct);
  end

  always @(negedge clk) if (rstN) begin
    #1;
    if (memWe) begin
      if (prevPend && (memAddr != prevAddr || memData != prevData)) holdBad++;
      if (!cpuReset) rstBad++;
      if (memReady) begin
        if (int'(memAddr) != wrCount || memData != romByte(expSel, wrCount)) begin
          if (firstBadAddr < 0) begin firstBadAddr = memAddr; firstBadData = memData; end
          wrBad++;
        end
        wrCount++;
        prevPend = 0;
      end else begin
        prevPend = 1; prevAddr = memAddr; prevData = memData;
      end
    end else prevPend = 0;
    if (!prevScl && sclBus) begin hiCnt = 0; meas = slvTx; end
    if (sclBus) hiCnt++;
    if (prevScl && !sclBus && meas) begin
      sclSeen++;
      if (hiCnt != 2 * (quarterDiv + 1)) sclBad++;
      meas = 0;
    end
    prevScl = sclBus;
  end

  // ---------------- sequences ----------------
  task automatic startRun(input int sel, input int q, input int rp, input bit p0,
                          input bit p1, input int ff);
    rstN = 0;
    imgSel = 1'(sel); quarterDiv = 12'(q); readyPct = rp; expSel = sel;
    present[0] = p0; present[1] = p1; failFirst = ff;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    check(cpuReset === 1'b1 && sclLow === 1'b0 && sdaLow === 1'b0 &&
          memWe === 1'b0 && errFlag === 1'b0, "R1 reset state",
          {cpuReset, sclLow, sdaLow, memWe, errFlag}, 5'b10000);
    slvActive = 0; slvTx = 0; txPending = 0; slvLow = 0; nackFail = 0;
    startCnt = 0; stopCnt = 0; attempts = 0; txCount = 0; masterAcks = 0;
    nackIdx = -1; logW = -1; logHi = -1; logLo = -1; logR = -1;
    rsSeen = 0; stopAfterNack = 0; gapBad = 0; gapSeen = 0;
    wrCount = 0; wrBad = 0; holdBad = 0; rstBad = 0; firstBadAddr = -1;
    sclBad = 0; sclSeen = 0; meas = 0; prevPend = 0;
    rstN = 1;
  endtask

  task automatic goodRun(input int sel, input int q, input int rp, input bit p0,
                         input bit p1, input int ff);
    int n;
    startRun(sel, q, rp, p0, p1, ff);
    n = 0;
    while (cpuReset && !errFlag && n < 40000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    check(!cpuReset && !errFlag, "R2 cpu released after load", {cpuReset, errFlag}, 0);
    check(stopAfterNack && stopCnt >= 1, "R2 release follows STOP", stopCnt, 1);
    check(rstBad == 0, "R2 cpu held during writes", rstBad, 0);
    check(!sclLow && !sdaLow, "R2 bus released", {sclLow, sdaLow}, 0);
    check(logW == ((8'h50 + sel) << 1), "R3 write address byte", logW, (8'h50 + sel) << 1);
    check(logR == (((8'h50 + sel) << 1) | 1), "R3 read address byte", logR,
          ((8'h50 + sel) << 1) | 1);
    check(logHi == 0 && logLo == 0 && rsSeen, "R4 word address then repeated START",
          logHi * 256 + logLo, 0);
    check(masterAcks == IMG - 1, "R5 master acks", masterAcks, IMG - 1);
    check(nackIdx == IMG - 1 && txCount == IMG, "R5 NACK on last byte", nackIdx, IMG - 1);
    check(wrCount == IMG, "R6 write count", wrCount, IMG);
    check(wrBad == 0, "R6 write address/data", firstBadData, romByte(sel, firstBadAddr));
    check(holdBad == 0, "R7 write held until ready", holdBad, 0);
    check(sclBad == 0 && sclSeen > 0, "R10 SCL high time", sclBad, 0);
    if (ff > 0) begin
      check(attempts == ff + 1, "R8 retry attempt count", attempts, ff + 1);
      check(gapBad == 0 && gapSeen == ff, "R8 retry pause", gapSeen, ff);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, sc;
    void'($urandom(32'd20240611));
    // directed: fastest divider, RAM always ready
    goodRun(0, 0, 100, 1, 1, 0);
    // directed: upper device, slow RAM, both present
    goodRun(1, 3, 15, 1, 1, 0);
    // random mixes
    for (int k = 0; k < 3; k++)
      goodRun($urandom % 2, $urandom % 4, 10 + ($urandom % 91), 1, 1, 0);
    // device answers on its third attempt
    goodRun(0, 2, 50, 1, 0, 2);
    // selected device absent: error path
    startRun(1, 1, 100, 1, 0, 0);
    n = 0;
    while (!errFlag && n < 40000) begin @(negedge clk); n++; end
    check(errFlag === 1'b1, "R9 error flag set", errFlag, 1);
    check(attempts == MAXT, "R9 attempt count", attempts, MAXT);
    check(gapBad == 0 && gapSeen == MAXT - 1, "R8 pause before each retry", gapSeen, MAXT - 1);
    sc = startCnt;
    repeat (2000) @(negedge clk);
    check(startCnt == sc && !sclLow && !sdaLow, "R9 bus quiet after error", startCnt, sc);
    check(errFlag && cpuReset && wrCount == 0, "R9 cpu held after error",
          {errFlag, cpuReset}, 3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule